// File: doc/BRIEF.md
# Serial Port Status Flag Controller

This block keeps the status flags of a UART/LIN-style serial port and raises its interrupt request. The transmit and receive datapaths send it one-cycle event pulses. These events report that the transmit buffer was moved into the shifter, that a frame finished, that a received byte reached the data register, that the line went idle, that a LIN header fault occurred, or that an overrun occurred. The block turns each event into a sticky flag in a status byte, which the bus reads.

Flags are cleared only by a two-step bus sequence. The first step is a read of the status register, which arms the sequence. The second step is an access to the data register. A data write clears the transmit-side flags, and a data read clears the receive-side flags. Only one data access is consumed per arming. The idle flag can fire only once per received byte.

The header-error flag is held while the sync-field lock input is asserted. The interrupt request is the registered OR of the flags whose enable inputs are high.

Top module: `sci_flag_ctrl`

## Requirements
- R1: After a synchronous reset all flags read 0 and `irq` is 0. Status bits 2..0 always read 0.
- R2: The status byte layout is: bit 7 buffer-empty, bit 6 frame-complete, bit 5 receive-ready, bit 4 idle, bit 3 header-error. `ev_txbuf_moved` sets bit 7 and `ev_rx_loaded` sets bit 5; each shows at the next clock.
- R3: Bits 7 and 6 are cleared only by `dat_wr` in a cycle after an `st_rd`. A `dat_wr` that no status read preceded, or a `dat_rd`, leaves them unchanged.
- R4: Bits 5, 4 and 3 are cleared only by `dat_rd` in a cycle after an `st_rd`.
- R5: An `st_rd` arms exactly one data access. The first `dat_rd` or `dat_wr` after it drops the arming, so a second data access clears nothing.
- R6: `ev_frame_done` sets bit 6 only when `ev_frame_is_data` is high in the same cycle. A preamble or break frame leaves bit 6 unchanged.
- R7: Once `ev_idle_seen` has set bit 4, later idle events are ignored until an `ev_rx_loaded` pulse re-arms idle detection. Detection is armed after reset.
- R8: Bit 3 is set by `ev_hdr_fault` (covering a corrupted sync field or a header timeout) and also by `ev_overrun`.
- R9: While `sync_hold` is high, bit 3 cannot be cleared. Once `sync_hold` is low, the normal clear sequence clears it.
- R10: A set event in the same cycle as a clear of that flag leaves the flag set.
- R11: `irq` at each clock becomes the OR of the new flags ANDed with the enables sampled at that edge. The enable pairings are: `en_tx` with bit 7, `en_tc` with bit 6, `en_rx` with bits 5 and 3, and `en_idle` with bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_txbuf_moved | input | 1 | Transmit buffer moved into shifter |
| ev_frame_done | input | 1 | Transmit frame finished |
| ev_frame_is_data | input | 1 | Finished frame carried data (low for preamble/break) |
| ev_rx_loaded | input | 1 | Received byte placed in data register |
| ev_idle_seen | input | 1 | Idle line detected |
| ev_hdr_fault | input | 1 | LIN header sync corruption or timeout |
| ev_overrun | input | 1 | Receive overrun |
| sync_hold | input | 1 | Sync-field lock active |
| st_rd | input | 1 | Status register read strobe |
| dat_rd | input | 1 | Data register read strobe |
| dat_wr | input | 1 | Data register write strobe |
| en_tx | input | 1 | Buffer-empty interrupt enable |
| en_tc | input | 1 | Frame-complete interrupt enable |
| en_rx | input | 1 | Receive-ready and header-error interrupt enable |
| en_idle | input | 1 | Idle interrupt enable |
| status_o | output | 8 | Status byte |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the following properties on every cycle:
- Each flag follows its set, clear and hold rules, with the set winning over a clear.
- An arming is dropped after one data access.
- A non-data frame cannot raise the frame-complete flag.
- Idle cannot fire twice without a received byte in between.
- The header flag survives while the lock is held.
- `irq` follows the enabled flags.

Only the bench scenarios show the following:
- The cross-group independence of the two clear paths.
- That an unarmed data access really has no effect.
- The full re-arm cycle of the idle flag.
- The release of the header flag once the lock drops.

These are shown by comparing every cycle against a behavioural model.

// File: rtl/sci_flag_pkg.sv
package sci_flag_pkg;
  localparam int NFLAG  = 5;
  // flag vector index; status bit = index + (status width - NFLAG)
  localparam int F_HDR  = 0;
  localparam int F_IDLE = 1;
  localparam int F_RDR  = 2;
  localparam int F_TC   = 3;
  localparam int F_TDRE = 4;
endpackage

// File: rtl/sci_flag_bit.sv
module sci_flag_bit #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o,
  output logic nxt_o
);
  logic q_r;

  // set has priority so that no hardware event is lost
  always_comb nxt_o = set_i | (q_r & ~clr_i);

  always_ff @(posedge clk) begin
    if (rst) q_r <= RST_VAL;
    else     q_r <= nxt_o;
  end

  assign q_o = q_r;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q_o); // R10
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !q_o); // R3
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i) |=> $stable(q_o)); // R4
endmodule

// File: rtl/sci_clear_seq.sv
module sci_clear_seq (
  input  logic clk,
  input  logic rst,
  input  logic st_rd,
  input  logic dat_rd,
  input  logic dat_wr,
  output logic clr_tx,
  output logic clr_rx
);
  logic armed_q;
  logic access;

  always_comb begin
    access = dat_rd | dat_wr;
    clr_tx = armed_q & dat_wr;
    clr_rx = armed_q & dat_rd;
  end

  always_ff @(posedge clk) begin
    if (rst)         armed_q <= 1'b0;
    else if (st_rd)  armed_q <= 1'b1;
    else if (access) armed_q <= 1'b0;
  end

  AST_ARM_ON_READ: assert property (@(posedge clk) disable iff (rst)
    st_rd |=> armed_q); // R5
  AST_ARM_DROPS: assert property (@(posedge clk) disable iff (rst)
    (access && !st_rd) |=> (!clr_tx && !clr_rx)); // R5
endmodule

// File: rtl/sci_idle_gate.sv
module sci_idle_gate (
  input  logic clk,
  input  logic rst,
  input  logic idle_ev,
  input  logic rx_ev,
  output logic idle_set
);
  logic rearm_q;

  always_comb idle_set = idle_ev & rearm_q;

  always_ff @(posedge clk) begin
    if (rst)           rearm_q <= 1'b1;
    else if (rx_ev)    rearm_q <= 1'b1;
    else if (idle_set) rearm_q <= 1'b0;
  end

  AST_IDLE_ONCE: assert property (@(posedge clk) disable iff (rst)
    (idle_set && !rx_ev) |=> !idle_set); // R7
endmodule

// File: rtl/sci_irq_merge.sv
module sci_irq_merge #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flag_nxt,
  input  logic [N-1:0] en,
  output logic         irq_o
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(flag_nxt & en);
  end

  assign irq_o = irq_q;

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (|(flag_nxt & en)) |=> irq_o); // R11
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(|(flag_nxt & en)) |=> !irq_o); // R11
endmodule

// File: rtl/sci_flag_ctrl.sv
module sci_flag_ctrl
  import sci_flag_pkg::*;
#(
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_txbuf_moved,
  input  logic              ev_frame_done,
  input  logic              ev_frame_is_data,
  input  logic              ev_rx_loaded,
  input  logic              ev_idle_seen,
  input  logic              ev_hdr_fault,
  input  logic              ev_overrun,
  input  logic              sync_hold,
  input  logic              st_rd,
  input  logic              dat_rd,
  input  logic              dat_wr,
  input  logic              en_tx,
  input  logic              en_tc,
  input  logic              en_rx,
  input  logic              en_idle,
  output logic [STAT_W-1:0] status_o,
  output logic              irq
);
  localparam int PAD = STAT_W - NFLAG;

  logic             clr_tx, clr_rx, idle_set;
  logic [NFLAG-1:0] set_v, clr_v, en_v, flag_q, flag_nxt;

  sci_clear_seq u_seq (
    .clk(clk), .rst(rst), .st_rd(st_rd), .dat_rd(dat_rd), .dat_wr(dat_wr),
    .clr_tx(clr_tx), .clr_rx(clr_rx)
  );

  sci_idle_gate u_idle (
    .clk(clk), .rst(rst), .idle_ev(ev_idle_seen), .rx_ev(ev_rx_loaded),
    .idle_set(idle_set)
  );

  always_comb begin
    set_v[F_TDRE] = ev_txbuf_moved;
    set_v[F_TC]   = ev_frame_done & ev_frame_is_data;
    set_v[F_RDR]  = ev_rx_loaded;
    set_v[F_IDLE] = idle_set;
    set_v[F_HDR]  = ev_hdr_fault | ev_overrun;

    clr_v[F_TDRE] = clr_tx;
    clr_v[F_TC]   = clr_tx;
    clr_v[F_RDR]  = clr_rx;
    clr_v[F_IDLE] = clr_rx;
    clr_v[F_HDR]  = clr_rx & ~sync_hold;

    en_v[F_TDRE]  = en_tx;
    en_v[F_TC]    = en_tc;
    en_v[F_RDR]   = en_rx;
    en_v[F_IDLE]  = en_idle;
    en_v[F_HDR]   = en_rx;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    sci_flag_bit #(.RST_VAL(1'b0)) u_bit (
      .clk(clk), .rst(rst), .set_i(set_v[i]), .clr_i(clr_v[i]),
      .q_o(flag_q[i]), .nxt_o(flag_nxt[i])
    );
  end

  sci_irq_merge #(.N(NFLAG)) u_irq (
    .clk(clk), .rst(rst), .flag_nxt(flag_nxt), .en(en_v), .irq_o(irq)
  );

  assign status_o = {flag_q, {PAD{1'b0}}};

  AST_TC_DATA_ONLY: assert property (@(posedge clk) disable iff (rst)
    (!status_o[PAD+F_TC] && !(ev_frame_done && ev_frame_is_data))
      |=> !status_o[PAD+F_TC]); // R6
  AST_HDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (sync_hold && status_o[PAD+F_HDR]) |=> status_o[PAD+F_HDR]); // R9
  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    status_o[PAD-1:0] == '0); // R1
endmodule

// File: tb/sci_flag_ctrl_test.sv
module sci_flag_ctrl_test;
  logic clk = 1'b0, rst = 1'b1;
  logic ev_txbuf_moved = 0, ev_frame_done = 0, ev_frame_is_data = 0;
  logic ev_rx_loaded = 0, ev_idle_seen = 0, ev_hdr_fault = 0, ev_overrun = 0;
  logic sync_hold = 0, st_rd = 0, dat_rd = 0, dat_wr = 0;
  logic en_tx = 0, en_tc = 0, en_rx = 0, en_idle = 0;
  logic [7:0] status_o;
  logic irq;

  int tests = 0, fails = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural reference state
  bit m_tdre, m_tc, m_rdr, m_idle, m_hdr, m_arm, m_rearm, m_irq;

  always #10 clk = ~clk;

  sci_flag_ctrl uut (.*);

  always @(posedge clk) begin
    bit acc_ok_w, acc_ok_r, iset;
    if (rst) begin
      m_tdre = 0; m_tc = 0; m_rdr = 0; m_idle = 0; m_hdr = 0;
      m_arm = 0; m_rearm = 1; m_irq = 0;
    end else begin
      acc_ok_w = m_arm && dat_wr;
      acc_ok_r = m_arm && dat_rd;
      iset = ev_idle_seen && m_rearm;
      if (acc_ok_w) begin m_tdre = 0; m_tc = 0; end
      if (acc_ok_r) begin m_rdr = 0; m_idle = 0; if (!sync_hold) m_hdr = 0; end
      if (ev_txbuf_moved) m_tdre = 1;
      if (ev_frame_done && ev_frame_is_data) m_tc = 1;
      if (ev_rx_loaded) m_rdr = 1;
      if (iset) m_idle = 1;
      if (ev_hdr_fault || ev_overrun) m_hdr = 1;
      if (st_rd) m_arm = 1; else if (dat_rd || dat_wr) m_arm = 0;
      if (ev_rx_loaded) m_rearm = 1; else if (iset) m_rearm = 0;
      m_irq = (m_tdre && en_tx) || (m_tc && en_tc) || ((m_rdr || m_hdr) && en_rx)
              || (m_idle && en_idle);
    end
  end

  task automatic chk(string req, logic [8:0] act, logic [8:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done)
      chk({cur_req, " cycle"}, {status_o, irq},
          {m_tdre, m_tc, m_rdr, m_idle, m_hdr, 3'b000, m_irq});
  end

  task automatic step();
    @(posedge clk); #1;
    ev_txbuf_moved = 0; ev_frame_done = 0; ev_frame_is_data = 0;
    ev_rx_loaded = 0; ev_idle_seen = 0; ev_hdr_fault = 0; ev_overrun = 0;
    st_rd = 0; dat_rd = 0; dat_wr = 0;
    @(negedge clk);
  endtask

  task automatic bit_chk(string req, int b, logic exp);
    chk(req, {8'h00, status_o[b]}, {8'h00, exp});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    step();
    cur_req = "R1";
    chk("R1 reset", {status_o, irq}, 9'h000);

    cur_req = "R2"; ev_txbuf_moved = 1; step();
    bit_chk("R2 tdre set", 7, 1);
    cur_req = "R3"; dat_wr = 1; step();
    bit_chk("R3 unarmed write ignored", 7, 1);
    st_rd = 1; step(); dat_rd = 1; step();
    bit_chk("R3 data read keeps tdre", 7, 1);
    st_rd = 1; step(); dat_wr = 1; step();
    bit_chk("R3 armed write clears", 7, 0);

    cur_req = "R6"; ev_frame_done = 1; ev_frame_is_data = 0; step();
    bit_chk("R6 break frame", 6, 0);
    ev_frame_done = 1; ev_frame_is_data = 1; step();
    bit_chk("R6 data frame", 6, 1);
    st_rd = 1; step(); dat_wr = 1; step();
    bit_chk("R3 tc cleared", 6, 0);

    cur_req = "R4"; ev_rx_loaded = 1; step();
    bit_chk("R2 rdr set", 5, 1);
    st_rd = 1; step(); dat_wr = 1; step();
    bit_chk("R4 write keeps rdr", 5, 1);
    st_rd = 1; step(); dat_rd = 1; step();
    bit_chk("R4 armed read clears", 5, 0);
    cur_req = "R5"; ev_rx_loaded = 1; step(); dat_rd = 1; step();
    bit_chk("R5 second access no clear", 5, 1);
    st_rd = 1; step(); dat_rd = 1; step(); dat_rd = 1; ev_rx_loaded = 1; step();
    dat_rd = 1; step();
    bit_chk("R5 arming used once", 5, 1);
    st_rd = 1; step(); dat_rd = 1; step();

    cur_req = "R7"; ev_idle_seen = 1; step();
    bit_chk("R7 idle set", 4, 1);
    st_rd = 1; step(); dat_rd = 1; step();
    ev_idle_seen = 1; step();
    bit_chk("R7 idle not re-set", 4, 0);
    ev_rx_loaded = 1; step(); ev_idle_seen = 1; step();
    bit_chk("R7 idle re-armed", 4, 1);
    st_rd = 1; step(); dat_rd = 1; step();

    cur_req = "R8"; ev_overrun = 1; step();
    bit_chk("R8 overrun sets hdr", 3, 1);
    st_rd = 1; step(); dat_rd = 1; step();
    bit_chk("R4 hdr cleared", 3, 0);
    ev_hdr_fault = 1; step();
    bit_chk("R8 fault sets hdr", 3, 1);
    cur_req = "R9"; sync_hold = 1; st_rd = 1; step(); dat_rd = 1; step();
    bit_chk("R9 held", 3, 1);
    sync_hold = 0; step(); st_rd = 1; step(); dat_rd = 1; step();
    bit_chk("R9 released clears", 3, 0);

    cur_req = "R10"; st_rd = 1; step(); dat_rd = 1; ev_rx_loaded = 1; step();
    bit_chk("R10 set wins", 5, 1);
    st_rd = 1; step(); dat_rd = 1; step();

    cur_req = "R11"; ev_txbuf_moved = 1; step();
    chk("R11 disabled", {8'h00, irq}, 9'h000);
    en_tx = 1; step();
    chk("R11 enabled", {8'h00, irq}, 9'h001);
    en_tx = 0; en_rx = 1; ev_overrun = 1; step();
    chk("R11 rx enable via hdr", {8'h00, irq}, 9'h001);
    en_rx = 0; step();
    chk("R11 all disabled", {8'h00, irq}, 9'h000);
    chk("R1 low bits", {6'h00, status_o[2:0]}, 9'h000);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule